// File: doc/BRIEF.md
# Two-Way Associative Read Cache

This block is a small read-only data cache that sits between a processor load port and a slow word memory. It holds eight one-word lines, organised as four sets with two ways each. A byte address selects one set. Both ways of that set compare their stored tags against the address in the same cycle. A matching valid way returns its word in that cycle, so the processor sees the data without waiting.

When neither way matches, the cache raises a stall and fetches the word-aligned address from memory through a request/valid handshake. It writes the returned word into a victim way. The next cycle then hits on the address that the processor is still holding. Each set keeps one recency bit that names its least recently used way. An empty way is filled before any eviction takes place. Stores, write-back and coherence are outside this block.

Top module: `assoc2_rd_cache`

## Requirements
- R1: Address bits [1:0] are ignored. Bits [3:2] select the set and bits [31:4] form the tag. Addresses 0x00 and 0x03 therefore name the same word, and 0x04, 0x24 and 0x54 all map to set 1.
- R2: On a hit, cpu_hit is 1, cpu_stall is 0 and cpu_rdata carries the cached word in the same cycle as the request, and mem_req stays 0.
- R3: On a miss, cpu_stall is 1 from the request cycle on. mem_req is then raised with mem_addr equal to the request address with bits [1:0] cleared. mem_req and mem_addr hold until mem_valid is seen. The word is written on that edge, and the held request hits with that word in the following cycle.
- R4: Two words of the same set reside together. Ten alternating reads of 0x04 and 0x24 produce exactly 2 misses.
- R5: A miss fills an invalid way when the set has one, and it prefers way 0 when both ways are invalid.
- R6: A miss in a set whose two ways are both valid evicts the way named by the set's recency bit. Reads of 0x04 then 0x24 then 0x54 evict 0x04 and keep 0x24.
- R7: Every hit and every fill sets the set's recency bit to the way that was not accessed. Value 0 names way 0 and value 1 names way 1.
- R8: Reset clears all valid bits and recency bits and returns the controller to lookup. After reset every read misses, and with no request active cpu_hit, cpu_stall and mem_req are 0.
- R9: While cpu_req is 0 and no fetch is in progress, cpu_hit, cpu_stall and mem_req are 0, even when cpu_addr names a cached word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Read request, held with cpu_addr while stalled |
| cpu_addr | input | 32 | Byte address of the read |
| cpu_rdata | output | 32 | Word returned on a hit |
| cpu_hit | output | 1 | Request hits this cycle |
| cpu_stall | output | 1 | Request cannot finish this cycle |
| mem_req | output | 1 | Fetch request to memory |
| mem_addr | output | 32 | Word-aligned fetch address |
| mem_valid | input | 1 | Memory returns the requested word this cycle |
| mem_rdata | input | 32 | Word returned by memory |

## Verification
Hit results are combinational, so the bench samples cpu_hit and cpu_rdata one time unit after it drives an address at a falling edge. The recency update from that hit is then committed at the next rising edge, before the next access is driven. A miss shows cpu_stall in the same settle window. mem_req appears one rising edge later, and the memory model answers after a latency that varies between 0 and 3 cycles. The bench waits at falling edges until cpu_stall drops and reads the hit in that cycle, which is the cycle after mem_valid was sampled. This makes miss counts and data checks independent of the memory latency.

// File: rtl/a2c_pkg.sv
package a2c_pkg;

  typedef enum logic {
    ST_LOOK = 1'b0,
    ST_FILL = 1'b1
  } a2c_state_t;

  // Victim way: first invalid way (way 0 first), otherwise the LRU way.
  function automatic logic pick_victim(input logic v0, input logic v1, input logic lru);
    logic w;
    if (!v0)      w = 1'b0;
    else if (!v1) w = 1'b1;
    else          w = lru;
    return w;
  endfunction

  // Recency value after touching a way: point at the other way.
  function automatic logic lru_after(input logic touched_way);
    return ~touched_way;
  endfunction

endpackage

// File: rtl/a2c_way_bank.sv
module a2c_way_bank #(
  parameter int SETS   = 4,
  parameter int SET_W  = 2,
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic [SETS-1:0]   valid_vec
);

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q[wr_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      data_q[wr_set] <= wr_data;
    end
  end

  assign rd_valid  = valid_q[rd_set];
  assign rd_tag    = tag_q[rd_set];
  assign rd_data   = data_q[rd_set];
  assign valid_vec = valid_q;

endmodule

// File: rtl/a2c_tag_match.sv
module a2c_tag_match #(
  parameter int TAG_W = 28
) (
  input  logic             entry_valid,
  input  logic [TAG_W-1:0] entry_tag,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             match
);

  assign match = entry_valid && (entry_tag == probe_tag);

endmodule

// File: rtl/a2c_lru_bits.sv
module a2c_lru_bits #(
  parameter int SETS  = 4,
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic             touch_way,
  input  logic [SET_W-1:0] rd_set,
  output logic             lru_way,
  output logic [SETS-1:0]  lru_vec
);
  import a2c_pkg::*;

  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru_q <= '0;
    else if (touch_en) lru_q[touch_set] <= lru_after(touch_way);
  end

  assign lru_way = lru_q[rd_set];
  assign lru_vec = lru_q;

endmodule

// File: rtl/assoc2_rd_cache.sv
module assoc2_rd_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 2,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata
);
  import a2c_pkg::*;

  localparam int WAYS  = 2;
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFS_W - SET_W;
  localparam int LA_W  = ADDR_W - OFS_W;

  // Lookup fields of the incoming address
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] probe_tag;
  assign set_idx   = cpu_addr[OFS_W +: SET_W];
  assign probe_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  // Controller state
  a2c_state_t       state_q;
  logic [LA_W-1:0]  fill_la_q;
  logic             victim_q;
  logic [SET_W-1:0] fill_set;
  logic [TAG_W-1:0] fill_tag;
  assign fill_set = fill_la_q[SET_W-1:0];
  assign fill_tag = fill_la_q[LA_W-1 -: TAG_W];

  // Named events for checks
  logic             in_look;
  logic             hit_any;
  logic             hit_way;
  logic             evt_hit;
  logic             evt_miss;
  logic             evt_fill;
  logic             lru_cur;
  logic             victim_now;
  logic [SETS-1:0]  lru_vec;

  logic [WAYS-1:0]   way_hit;
  logic [WAYS-1:0]   way_valid;
  logic [TAG_W-1:0]  way_tag  [WAYS];
  logic [DATA_W-1:0] way_data [WAYS];
  logic [SETS-1:0]   way_vvec [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic wr_this;
    assign wr_this = evt_fill && (victim_q == w[0]);

    a2c_way_bank #(
      .SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (set_idx),
      .wr_en    (wr_this),
      .wr_set   (fill_set),
      .wr_tag   (fill_tag),
      .wr_data  (mem_rdata),
      .rd_valid (way_valid[w]),
      .rd_tag   (way_tag[w]),
      .rd_data  (way_data[w]),
      .valid_vec(way_vvec[w])
    );

    a2c_tag_match #(.TAG_W(TAG_W)) u_match (
      .entry_valid(way_valid[w]),
      .entry_tag  (way_tag[w]),
      .probe_tag  (probe_tag),
      .match      (way_hit[w])
    );
  end

  assign in_look  = (state_q == ST_LOOK);
  assign hit_any  = |way_hit;
  assign hit_way  = way_hit[1];
  assign evt_hit  = in_look && cpu_req && hit_any;
  assign evt_miss = in_look && cpu_req && !hit_any;
  assign evt_fill = !in_look && mem_valid;

  a2c_lru_bits #(.SETS(SETS), .SET_W(SET_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch_en (evt_hit || evt_fill),
    .touch_set(evt_fill ? fill_set : set_idx),
    .touch_way(evt_fill ? victim_q : hit_way),
    .rd_set   (set_idx),
    .lru_way  (lru_cur),
    .lru_vec  (lru_vec)
  );

  assign victim_now = pick_victim(way_valid[0], way_valid[1], lru_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_LOOK;
      fill_la_q <= '0;
      victim_q  <= 1'b0;
    end else if (evt_miss) begin
      state_q   <= ST_FILL;
      fill_la_q <= cpu_addr[ADDR_W-1:OFS_W];
      victim_q  <= victim_now;
    end else if (evt_fill) begin
      state_q   <= ST_LOOK;
    end
  end

  assign cpu_rdata = hit_way ? way_data[1] : way_data[0];
  assign cpu_hit   = evt_hit;
  assign cpu_stall = evt_miss || !in_look;
  assign mem_req   = !in_look;
  assign mem_addr  = {fill_la_q, {OFS_W{1'b0}}};

endmodule

// File: rtl/a2c_checker.sv
module a2c_checker #(
  parameter int SETS  = 4,
  parameter int SET_W = 2,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_hit,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              evt_hit,
  input logic              evt_fill,
  input logic              hit_way,
  input logic              fill_way,
  input logic [SET_W-1:0]  set_idx,
  input logic [SET_W-1:0]  fill_set,
  input logic [SETS-1:0]   lru_vec,
  input logic [SETS-1:0]   valid_w0,
  input logic [SETS-1:0]   valid_w1
);

  // R2
  hit_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (!cpu_stall && !mem_req));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R3
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> !mem_req);

  // R3
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R5
  fill_empty_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fill && !valid_w0[fill_set]) |-> (fill_way == 1'b0));

  // R6
  evict_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fill && valid_w0[fill_set] && valid_w1[fill_set]) |-> (fill_way == lru_vec[fill_set]));

  // R7
  hit_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> (lru_vec[$past(set_idx)] == !$past(hit_way)));

  // R7
  fill_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fill |=> (lru_vec[$past(fill_set)] == !$past(fill_way)));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (lru_vec == '0 && valid_w0 == '0 && valid_w1 == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && !mem_req) |-> (!cpu_stall && !cpu_hit));

endmodule

bind assoc2_rd_cache a2c_checker #(
  .SETS(SETS), .SET_W(SET_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_req  (cpu_req),
  .cpu_hit  (cpu_hit),
  .cpu_stall(cpu_stall),
  .mem_req  (mem_req),
  .mem_valid(mem_valid),
  .mem_addr (mem_addr),
  .evt_hit  (evt_hit),
  .evt_fill (evt_fill),
  .hit_way  (hit_way),
  .fill_way (victim_q),
  .set_idx  (set_idx),
  .fill_set (fill_set),
  .lru_vec  (lru_vec),
  .valid_w0 (way_vvec[0]),
  .valid_w1 (way_vvec[1])
);

// File: tb/test_assoc2_rd_cache.sv
`timescale 1ns/1ps
module test_assoc2_rd_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_hit;
  logic        cpu_stall;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  logic [31:0] fill_expect = '0;

  always #2 clk = ~clk;

  assoc2_rd_cache i_assoc2_rd_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h3C5A_0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Vector table: {address, expected hit on first look}
  localparam logic [32:0] VEC [22] = '{
    {32'h04, 1'b0}, {32'h24, 1'b0}, {32'h04, 1'b1}, {32'h24, 1'b1},
    {32'h04, 1'b1}, {32'h24, 1'b1}, {32'h04, 1'b1}, {32'h24, 1'b1},
    {32'h04, 1'b1}, {32'h24, 1'b1},
    {32'h54, 1'b0}, {32'h24, 1'b1}, {32'h04, 1'b0}, {32'h54, 1'b0},
    {32'h08, 1'b0}, {32'h0C, 1'b0}, {32'h08, 1'b1}, {32'h00, 1'b0},
    {32'h03, 1'b1}, {32'h04, 1'b1}, {32'h24, 1'b0}, {32'h04, 1'b1}
  };

  // Memory model with varying latency
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_valid) begin
        check("R3 mem_addr word aligned", mem_addr, fill_expect);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          check("R3 stall held during fetch", {31'd0, cpu_stall}, 32'd1);
        end
        mem_valid = 1'b1;
        mem_rdata = mem_word(mem_addr);
        @(negedge clk);
        mem_valid = 1'b0;
        lat = (lat + 1) % 4;
      end
    end
  end

  task automatic do_read(input logic [31:0] a, output bit first_hit,
                         output bit final_hit, output logic [31:0] data);
    @(negedge clk);
    cpu_req = 1'b1;
    cpu_addr = a;
    fill_expect = {a[31:2], 2'b00};
    #1;
    first_hit = !cpu_stall;
    for (int w = 0; w < 50 && cpu_stall; w++) begin
      @(negedge clk);
      #1;
    end
    final_hit = cpu_hit;
    data = cpu_rdata;
  endtask

  task automatic go_idle();
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  initial begin
    bit fh, lh;
    logic [31:0] d;
    int misses;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 hit after reset", {31'd0, cpu_hit}, 32'd0);
    check("R8 stall after reset", {31'd0, cpu_stall}, 32'd0);
    check("R8 mem_req after reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;

    // Vector walk: R1 R2 R4 R5 R6 R7
    misses = 0;
    for (int i = 0; i < 22; i++) begin
      do_read(VEC[i][32:1], fh, lh, d);
      if (!fh && i < 10) misses++;
      check($sformatf("R6 R7 hit/miss vector %0d", i), {31'd0, fh}, {31'd0, VEC[i][0]});
      check($sformatf("R2 R3 hit after settle vector %0d", i), {31'd0, lh}, 32'd1);
      check($sformatf("R1 R2 data vector %0d", i), d, mem_word({VEC[i][32:3], 2'b00}));
    end
    check("R4 misses in alternating ten reads", misses, 2);

    // R9: no request, address of a cached word
    go_idle();
    cpu_addr = 32'h04;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      check("R9 idle hit", {31'd0, cpu_hit}, 32'd0);
      check("R9 idle stall", {31'd0, cpu_stall}, 32'd0);
      check("R9 idle mem_req", {31'd0, mem_req}, 32'd0);
    end

    // R8: reset mid-run forgets contents
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 mem_req in reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    do_read(32'h04, fh, lh, d);
    check("R8 read misses after reset", {31'd0, fh}, 32'd0);
    // R5: second word of set goes to the empty way, first stays
    do_read(32'h44, fh, lh, d);
    check("R5 fill empty way miss", {31'd0, fh}, 32'd0);
    do_read(32'h04, fh, lh, d);
    check("R5 first word kept", {31'd0, fh}, 32'd1);
    check("R5 data kept", d, mem_word(32'h04));
    do_read(32'h44, fh, lh, d);
    check("R5 second word kept", {31'd0, fh}, 32'd1);
    // R7: last touch 0x44 -> 0x04 is LRU; 0x84 evicts it
    do_read(32'h84, fh, lh, d);
    do_read(32'h44, fh, lh, d);
    check("R7 recent word survives", {31'd0, fh}, 32'd1);
    do_read(32'h04, fh, lh, d);
    check("R7 LRU word evicted", {31'd0, fh}, 32'd0);
    go_idle();

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule